// File: doc/BRIEF.md
# Timestamped Event History Buffer

This block keeps a rolling log of the most recent events seen by a protection controller. Each time an event request is raised, the block assembles a 128-bit record and writes it into a circular store. The record holds the current UTC time as a seconds word plus a microseconds count, the monitor and control status words present at that moment, and the event's visibility, type, sub-type and detail fields. Once the store is full, each new event replaces the oldest one.

Host software reads the log in two steps. A start pulse freezes a view of the log: the position of the oldest record and the number of records present. Word requests then return that view one 32-bit word at a time, from the oldest record to the newest and from word 0 to word 3 within each record. Recording continues during a readout, and events that arrive after the start pulse are not part of the current view. The memory has a single port. When an event write and a host word read fall on the same cycle, the write is served and the read is held back by one cycle.

Top module: `evhist_buffer`

## Requirements
- R1: After reset, `rec_count` and `rd_left` are 0 and `rd_valid` is low.
- R2: A record consists of four 32-bit words. Word 0 is the UTC seconds value. Word 1 has the microseconds in bits 31:12 and the monitor status in bits 11:0. Word 2 has the control status in bits 31:16, the visibility in bits 15:14, the type in bits 13:8 and the sub-type in bits 7:0. Word 3 is the detail field. The time and status values are those present on the cycle the event is accepted.
- R3: `rec_count` goes up by one for each accepted event and stops at DEPTH (1024).
- R4: Once DEPTH records are stored, each new event overwrites the oldest record, and the 10-bit write position wraps from 1023 back to 0.
- R5: A `rd_start` pulse sets `rd_left` to the `rec_count` value from before that edge. It also positions the readout at the oldest stored record. Word requests then return records from oldest to newest, with words 0 to 3 in order within each record.
- R6: Events accepted after `rd_start` do not change `rd_left` or the set of records returned by the current readout.
- R7: If `ev_req` and a word request occur on the same cycle, `rd_valid` stays low on the following cycle and the word is delivered one cycle later.
- R8: A word request made while `rd_left` is 0 produces no `rd_valid` pulse.
- R9: A word request without a conflict is answered by a single-cycle `rd_valid` pulse, with `rd_data`, on the cycle after the request. `rd_left` goes down by one after the fourth word of a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req | input | 1 | Record an event on this cycle |
| ev_vis | input | 2 | Event visibility field |
| ev_type | input | 6 | Event type field |
| ev_sub | input | 8 | Event sub-type field |
| ev_detail | input | 32 | Event detail word |
| mon_status | input | 12 | Monitor status sampled into each record |
| ctl_status | input | 16 | Control status sampled into each record |
| utc_sec | input | 32 | Current UTC seconds |
| utc_usec | input | 20 | Current UTC microseconds |
| rd_start | input | 1 | Freeze a readout view of the log |
| rd_word_req | input | 1 | Fetch the next 32-bit word of the view |
| rd_data | output | 32 | Returned word |
| rd_valid | output | 1 | `rd_data` is valid on this cycle |
| rd_left | output | 11 | Records of the view not yet fully read |
| rec_count | output | 11 | Stored records, capped at DEPTH |

## Verification
The hardest state to reach is a readout that runs after the store has wrapped. In that state the oldest record sits in the middle of the memory and the view has to be walked across the 1023-to-0 address seam. The bench drives 1100 back-to-back events and then reads all 4096 words. It checks that the first word comes from event 76 and that every later word follows in order. A second scenario places a new event and a word request on the same edge in the middle of a readout. This exercises both the one-cycle stall and the rule that events arriving after the start pulse stay outside the view.

// File: rtl/evhist_pkg.sv
package evhist_pkg;

    localparam int WORD_W = 32;
    localparam int WORDS_PER_REC = 4;

    typedef struct packed {
        logic [31:0] detail;
        logic [15:0] ctl;
        logic [1:0]  vis;
        logic [5:0]  etype;
        logic [7:0]  sub;
        logic [19:0] usec;
        logic [11:0] mon;
        logic [31:0] sec;
    } hb_rec_t;

    typedef struct packed {
        logic [1:0]  vis;
        logic [5:0]  etype;
        logic [7:0]  sub;
        logic [31:0] detail;
    } ev_desc_t;

    function automatic hb_rec_t build_rec(
        input ev_desc_t    d,
        input logic [31:0] sec,
        input logic [19:0] usec,
        input logic [11:0] mon,
        input logic [15:0] ctl
    );
        hb_rec_t r;
        r.sec    = sec;
        r.usec   = usec;
        r.mon    = mon;
        r.ctl    = ctl;
        r.vis    = d.vis;
        r.etype  = d.etype;
        r.sub    = d.sub;
        r.detail = d.detail;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input hb_rec_t r, input logic [1:0] sel);
        logic [WORD_W-1:0] w;
        case (sel)
            2'd0:    w = r.sec;
            2'd1:    w = {r.usec, r.mon};
            2'd2:    w = {r.ctl, r.vis, r.etype, r.sub};
            default: w = r.detail;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/hb_store.sv
module hb_store
    import evhist_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  hb_rec_t           wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    input  logic [1:0]        rsel,
    output logic [WORD_W-1:0] rdata
);

    hb_rec_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= word_of(mem[raddr], rsel);
        end
    end

endmodule

// File: rtl/hb_wr_ctrl.sv
module hb_wr_ctrl #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_req,
    output logic [AW-1:0] wptr,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] FULL    = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_AD = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            count <= '0;
        end else if (ev_req) begin
            wptr <= (wptr == LAST_AD) ? '0 : wptr + 1'b1;
            if (count != FULL) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hb_rd_ctrl.sv
module hb_rd_ctrl #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_req,
    input  logic          rd_start,
    input  logic          rd_word_req,
    input  logic [AW-1:0] wptr,
    input  logic [CW-1:0] count,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output logic [1:0]    mem_rsel,
    output logic          rd_valid,
    output logic [CW-1:0] rd_left
);

    localparam logic [AW-1:0] LAST_AD = AW'(DEPTH - 1);

    logic          pend;
    logic          want;
    logic          svc;
    logic [AW-1:0] rptr;
    logic [1:0]    widx;
    logic [AW-1:0] oldest;

    always_comb begin
        want   = rd_word_req | pend;
        svc    = want & ~ev_req & ~rd_start & (rd_left != '0);
        oldest = wptr - count[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            rptr     <= '0;
            widx     <= '0;
            rd_left  <= '0;
            rd_valid <= 1'b0;
        end else if (rd_start) begin
            pend     <= 1'b0;
            rptr     <= oldest;
            widx     <= '0;
            rd_left  <= count;
            rd_valid <= 1'b0;
        end else begin
            pend     <= want & ev_req & (rd_left != '0);
            rd_valid <= svc;
            if (svc) begin
                widx <= widx + 1'b1;
                if (widx == 2'd3) begin
                    rptr    <= (rptr == LAST_AD) ? '0 : rptr + 1'b1;
                    rd_left <= rd_left - 1'b1;
                end
            end
        end
    end

    assign mem_re    = svc;
    assign mem_raddr = rptr;
    assign mem_rsel  = widx;

endmodule

// File: rtl/evhist_buffer.sv
module evhist_buffer
    import evhist_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_req,
    input  logic [1:0]  ev_vis,
    input  logic [5:0]  ev_type,
    input  logic [7:0]  ev_sub,
    input  logic [31:0] ev_detail,
    input  logic [11:0] mon_status,
    input  logic [15:0] ctl_status,
    input  logic [31:0] utc_sec,
    input  logic [19:0] utc_usec,
    input  logic        rd_start,
    input  logic        rd_word_req,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic [10:0] rd_left,
    output logic [10:0] rec_count
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    ev_desc_t      desc;
    hb_rec_t       rec;
    logic [AW-1:0] wptr;
    logic [CW-1:0] count;
    logic [CW-1:0] left;
    logic          mem_re;
    logic [AW-1:0] mem_raddr;
    logic [1:0]    mem_rsel;

    always_comb begin
        desc.vis    = ev_vis;
        desc.etype  = ev_type;
        desc.sub    = ev_sub;
        desc.detail = ev_detail;
        rec         = build_rec(desc, utc_sec, utc_usec, mon_status, ctl_status);
    end

    hb_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .ev_req (ev_req),
        .wptr   (wptr),
        .count  (count)
    );

    hb_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .ev_req      (ev_req),
        .rd_start    (rd_start),
        .rd_word_req (rd_word_req),
        .wptr        (wptr),
        .count       (count),
        .mem_re      (mem_re),
        .mem_raddr   (mem_raddr),
        .mem_rsel    (mem_rsel),
        .rd_valid    (rd_valid),
        .rd_left     (left)
    );

    hb_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (ev_req),
        .waddr (wptr),
        .wdata (rec),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rsel  (mem_rsel),
        .rdata (rd_data)
    );

    assign rd_left   = 11'(left);
    assign rec_count = 11'(count);

endmodule

// File: rtl/evhist_chk.sv
module evhist_chk #(
    parameter int DEPTH = 1024
) (
    input logic        clk,
    input logic        rst,
    input logic        ev_req,
    input logic        rd_start,
    input logic        rd_word_req,
    input logic        rd_valid,
    input logic [10:0] rd_left,
    input logic [10:0] rec_count
);

    localparam logic [10:0] FULL = 11'(DEPTH);

    // R3
    rec_count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        rec_count <= FULL);

    // R3
    rec_count_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_req && rec_count != FULL) |=> rec_count == $past(rec_count) + 11'd1);

    // R5
    view_snapshot_chk: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> rd_left == $past(rec_count));

    // R6
    view_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_start |=> rd_left <= $past(rd_left));

    // R7
    collide_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_req && rd_word_req && !rd_start) |=> !rd_valid);

    // R8
    empty_view_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_left) != 11'd0);

endmodule

bind evhist_buffer evhist_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_req      (ev_req),
    .rd_start    (rd_start),
    .rd_word_req (rd_word_req),
    .rd_valid    (rd_valid),
    .rd_left     (rd_left),
    .rec_count   (rec_count)
);

// File: tb/sim_evhist_buffer.sv
`timescale 1ns/1ps
module sim_evhist_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_req = 1'b0;
    logic [1:0]  ev_vis = '0;
    logic [5:0]  ev_type = '0;
    logic [7:0]  ev_sub = '0;
    logic [31:0] ev_detail = '0;
    logic [11:0] mon_status = '0;
    logic [15:0] ctl_status = '0;
    logic [31:0] utc_sec = '0;
    logic [19:0] utc_usec = '0;
    logic        rd_start = 1'b0;
    logic        rd_word_req = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [10:0] rd_left;
    logic [10:0] rec_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [127:0] m_mem [1024];
    int m_wptr, m_count, ev_n;
    int s_rptr, s_left, s_widx;

    always #2.5 clk = ~clk;

    evhist_buffer u0 (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input int n);
        logic [31:0] sec  = 32'h1000_0000 + n;
        logic [19:0] us   = 20'(n * 7);
        logic [11:0] mon  = 12'(n * 3);
        logic [15:0] ctl  = 16'(n) ^ 16'hA5A5;
        logic [1:0]  vis  = 2'(n);
        logic [5:0]  typ  = 6'(n >> 2);
        logic [7:0]  sub  = 8'(n * 5);
        logic [31:0] det  = 32'hDEAD_0000 ^ n;
        return {det, ctl, vis, typ, sub, us, mon, sec};
    endfunction

    task automatic drive_fields(input int n);
        logic [127:0] r = mk(n);
        utc_sec    = r[31:0];
        mon_status = r[43:32];
        utc_usec   = r[63:44];
        ev_sub     = r[71:64];
        ev_type    = r[77:72];
        ev_vis     = r[79:78];
        ctl_status = r[95:80];
        ev_detail  = r[127:96];
    endtask

    task automatic model_write();
        m_mem[m_wptr] = mk(ev_n);
        m_wptr = (m_wptr + 1) % 1024;
        if (m_count < 1024) m_count++;
        ev_n++;
    endtask

    function automatic logic [31:0] exp_word();
        return m_mem[s_rptr][32*s_widx +: 32];
    endfunction

    task automatic model_advance();
        s_widx++;
        if (s_widx == 4) begin
            s_widx = 0;
            s_rptr = (s_rptr + 1) % 1024;
            s_left--;
        end
    endtask

    task automatic send_ev();
        drive_fields(ev_n);
        ev_req = 1'b1;
        @(negedge clk);
        ev_req = 1'b0;
        model_write();
    endtask

    task automatic start_rd();
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        s_rptr = (m_wptr - m_count + 1024) % 1024;
        s_left = m_count;
        s_widx = 0;
    endtask

    task automatic read_word(input string req);
        rd_word_req = 1'b1;
        @(negedge clk);
        rd_word_req = 1'b0;
        check({req, " valid"}, 64'(rd_valid), 64'd1);
        check({req, " data"}, 64'(rd_data), 64'(exp_word()));
        model_advance();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ev_req = 1'b0; rd_start = 1'b0; rd_word_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_wptr = 0; m_count = 0; ev_n = 0;
        s_rptr = 0; s_left = 0; s_widx = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rec_count", 64'(rec_count), 64'd0);
        check("R1 rd_left", 64'(rd_left), 64'd0);
        check("R1 rd_valid", 64'(rd_valid), 64'd0);
    endtask

    task automatic t_basic();
        do_reset();
        for (int i = 0; i < 3; i++) send_ev();
        check("R3 count after 3", 64'(rec_count), 64'd3);
        start_rd();
        check("R5 rd_left snapshot", 64'(rd_left), 64'd3);
        // R2 explicit field positions for record 0
        read_word("R2 dw0");
        read_word("R2 dw1");
        read_word("R2 dw2");
        read_word("R2 dw3");
        @(negedge clk);
        check("R9 single-cycle valid", 64'(rd_valid), 64'd0);
        check("R9 rd_left after record", 64'(rd_left), 64'd2);
        for (int i = 0; i < 8; i++) read_word("R5 order");
        check("R5 rd_left drained", 64'(rd_left), 64'd0);
        rd_word_req = 1'b1;
        @(negedge clk);
        rd_word_req = 1'b0;
        check("R8 no valid when empty", 64'(rd_valid), 64'd0);
        @(negedge clk);
        check("R8 no late valid", 64'(rd_valid), 64'd0);
    endtask

    task automatic t_concurrent();
        do_reset();
        for (int i = 0; i < 4; i++) send_ev();
        start_rd();
        read_word("R6 pre");
        read_word("R6 pre");
        send_ev();
        send_ev();
        check("R6 rd_left unchanged", 64'(rd_left), 64'd4);
        check("R3 count grows", 64'(rec_count), 64'd6);
        // R7 collision: event and word request on the same edge
        drive_fields(ev_n);
        ev_req = 1'b1;
        rd_word_req = 1'b1;
        @(negedge clk);
        ev_req = 1'b0;
        rd_word_req = 1'b0;
        model_write();
        check("R7 stalled", 64'(rd_valid), 64'd0);
        @(negedge clk);
        check("R7 late valid", 64'(rd_valid), 64'd1);
        check("R7 late data", 64'(rd_data), 64'(exp_word()));
        model_advance();
        while (s_left > 0) read_word("R6 view");
        check("R6 view end", 64'(rd_left), 64'd0);
        rd_word_req = 1'b1;
        @(negedge clk);
        rd_word_req = 1'b0;
        check("R6 R8 no records past view", 64'(rd_valid), 64'd0);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < 1100; i++) send_ev();
        check("R3 saturate", 64'(rec_count), 64'd1024);
        start_rd();
        check("R4 rd_left full", 64'(rd_left), 64'd1024);
        rd_word_req = 1'b1;
        @(negedge clk);
        rd_word_req = 1'b0;
        check("R4 oldest is event 76", 64'(rd_data), 64'(32'h1000_0000 + 76));
        model_advance();
        while (s_left > 0) read_word("R4 wrapped order");
        check("R4 drained", 64'(rd_left), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_concurrent();
        t_wrap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule